// File: doc/BRIEF.md
# Fused Multiply-Add Exception Screen

This block inspects the three operands of a fused multiply-add before the arithmetic runs. The operation is `(A × C) + B`, with C as the multiplier and B as the addend. A 2-bit variant code selects one of four forms: plain multiply-add, multiply-subtract `(A×C) − B`, negated multiply-add `−((A×C)+B)` and negated multiply-subtract `−((A×C)−B)`. From the classes and signs of the inputs alone (zero, infinity, quiet NaN, signalling NaN, finite), it finds the invalid-operation cases and the NaN inputs. No product or sum is ever formed.

When an operand is a NaN or the operation is invalid, the block produces a ready-made result and raises an override flag, which tells the downstream datapath to discard its own arithmetic result. The block also keeps sticky exception bits. When the record flag is set, it loads a 4-bit condition field from the exception summary.

A small two-state controller (`ST_IDLE`, `ST_DONE`) marks when a registered verdict is on the outputs. The transitions are `ST_IDLE → ST_DONE` and `ST_DONE → ST_DONE` on `in_valid`, and `ST_DONE → ST_IDLE` when `in_valid` is low.

Top module: `fma_exc_screen`

## Requirements
- R1: All outputs are registered. `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise. Reset clears the controller, the sticky bits, the override flag and `cond`.
- R2: `st_vximz` is set when one of A and C is a zero and the other is an infinity, regardless of B.
- R3: `st_vxisi` is set under three conditions: the product is infinite, B is an infinity, and the sign of B differs from `sign(A) XOR sign(C)`. The product is infinite when one of A and C is infinite and the other is neither zero nor NaN. The sign of B is inverted first when `variant[0]` is 1 (codes 2'b01 and 2'b11 subtract). The outer negation (codes 2'b10 and 2'b11) has no effect on any flag.
- R4: `st_vxsnan` is set when any operand is a signalling NaN. A signalling NaN has an all-ones exponent, mantissa MSB 0 and a nonzero mantissa. A quiet NaN has an all-ones exponent and mantissa MSB 1.
- R5: When any operand is a NaN, the override result is the first NaN in the order A, B, C. It keeps its sign and payload and has mantissa MSB forced to 1.
- R6: When no operand is a NaN but R2 or R3 applies, the override result is the default quiet NaN: sign 0, exponent all ones, mantissa MSB 1 and all other mantissa bits 0.
- R7: `ovr_valid` is high exactly when `out_valid` is high and the screened operation had a NaN operand or an invalid case. The override result is never negated by the variant.
- R8: `st_fx` is set only when an operation turns at least one of `st_vximz`, `st_vxisi` or `st_vxsnan` from 0 to 1. `st_vx` always equals the OR of those three bits.
- R9: The exception bits and `st_fx` stay set until `clr`. A `clr` in the same cycle as an operation clears the old bits first, then merges in the flags of that operation.
- R10: When `in_valid` and `record` are both high, `cond` is loaded with {FX, FEX, VX, OX} in bits 3 down to 0, using the updated FX and VX. FEX and OX are always 0 in this block. In any other cycle, including a `clr`, `cond` is unchanged.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clears sticky exception bits and `st_fx` |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 1+EXP_W+MAN_W | Multiplicand A |
| op_b | input | 1+EXP_W+MAN_W | Addend B |
| op_c | input | 1+EXP_W+MAN_W | Multiplier C |
| variant | input | 2 | 00 madd, 01 msub, 10 nmadd, 11 nmsub |
| record | input | 1 | Update `cond` for this operation |
| out_valid | output | 1 | Screening verdict is on the outputs |
| ovr_valid | output | 1 | Downstream must use `ovr_result` |
| ovr_result | output | 1+EXP_W+MAN_W | Override result |
| st_fx | output | 1 | Sticky exception summary |
| st_vx | output | 1 | Invalid-operation summary |
| st_vximz | output | 1 | Sticky zero-times-infinity |
| st_vxisi | output | 1 | Sticky infinity-minus-infinity |
| st_vxsnan | output | 1 | Sticky signalling-NaN input |
| cond | output | 4 | Condition field {FX, FEX, VX, OX} |

## Verification
The bench builds the block with a 4-bit exponent and a 3-bit mantissa (EXP_W=4, MAN_W=3). In this format each operand class fits in one byte: signed zeros, signed infinities, a normal value, a subnormal value, and quiet and signalling NaNs with payloads. With eight such representatives per operand and all four variants, the full product of 2048 combinations is swept. This reaches every pairing of opposing infinities under each addend negation, every NaN priority order, and every record/no-record update. Directed sequences then cover sticky accumulation without a clear, a clear coinciding with an operation, and a clear leaving the condition field untouched.

// File: rtl/fma_cls_pkg.sv
package fma_cls_pkg;

    typedef enum logic [1:0] {
        VAR_MADD  = 2'b00,
        VAR_MSUB  = 2'b01,
        VAR_NMADD = 2'b10,
        VAR_NMSUB = 2'b11
    } fma_var_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } scr_state_e;

    typedef struct packed {
        logic sgn;
        logic zero;
        logic inf;
        logic qnan;
        logic snan;
    } fcls_t;

    typedef struct packed {
        logic vximz;
        logic vxisi;
        logic vxsnan;
    } inv_flags_t;

endpackage

// File: rtl/fma_cls_operand.sv
module fma_cls_operand
    import fma_cls_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic [EXP_W+MAN_W:0] val,
    output fcls_t                cls
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_max;
    logic             man_nz;

    assign exp_f   = val[W-2:MAN_W];
    assign man_f   = val[MAN_W-1:0];
    assign exp_max = &exp_f;
    assign man_nz  = |man_f;

    always_comb begin
        cls.sgn  = val[W-1];
        cls.zero = ~|exp_f & ~man_nz;
        cls.inf  = exp_max & ~man_nz;
        cls.qnan = exp_max & man_f[MAN_W-1];
        cls.snan = exp_max & ~man_f[MAN_W-1] & man_nz;
    end
endmodule

// File: rtl/fma_cls_invalid.sv
module fma_cls_invalid
    import fma_cls_pkg::*;
(
    input  fcls_t      ca,
    input  fcls_t      cb,
    input  fcls_t      cc,
    input  fma_var_e   variant,
    output inv_flags_t flg
);
    logic sub_b;
    logic a_nan, c_nan;
    logic prod_inf;
    logic unused_b_zero;

    assign unused_b_zero = cb.zero;

    always_comb begin
        unique case (variant)
            VAR_MADD, VAR_NMADD: sub_b = 1'b0;
            VAR_MSUB, VAR_NMSUB: sub_b = 1'b1;
            default:             sub_b = 1'b0;
        endcase
    end

    assign a_nan    = ca.qnan | ca.snan;
    assign c_nan    = cc.qnan | cc.snan;
    assign prod_inf = (ca.inf & ~cc.zero & ~c_nan) | (cc.inf & ~ca.zero & ~a_nan);

    always_comb begin
        flg.vximz  = (ca.zero & cc.inf) | (ca.inf & cc.zero);
        flg.vxisi  = prod_inf & cb.inf & ((ca.sgn ^ cc.sgn) != (cb.sgn ^ sub_b));
        flg.vxsnan = ca.snan | cb.snan | cc.snan;
    end
endmodule

// File: rtl/fma_cls_nan_pick.sv
module fma_cls_nan_pick #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic [EXP_W+MAN_W:0] ops [3],
    input  logic [2:0]           is_nan,
    output logic [EXP_W+MAN_W:0] res
);
    localparam int W = 1 + EXP_W + MAN_W;
    localparam logic [W-1:0] QBIT  = {{(W-MAN_W){1'b0}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [W-1:0] DFLT  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    // lowest index wins: scan from C back to A
    always_comb begin
        res = DFLT;
        for (int i = 2; i >= 0; i--) begin
            if (is_nan[i]) res = ops[i] | QBIT;
        end
    end
endmodule

// File: rtl/fma_exc_screen.sv
module fma_exc_screen
    import fma_cls_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 in_valid,
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    input  logic [EXP_W+MAN_W:0] op_c,
    input  logic [1:0]           variant,
    input  logic                 record,
    output logic                 out_valid,
    output logic                 ovr_valid,
    output logic [EXP_W+MAN_W:0] ovr_result,
    output logic                 st_fx,
    output logic                 st_vx,
    output logic                 st_vximz,
    output logic                 st_vxisi,
    output logic                 st_vxsnan,
    output logic [3:0]           cond
);
    localparam int W    = 1 + EXP_W + MAN_W;
    localparam int N_OP = 3;

    scr_state_e   state_q, state_d;
    logic [W-1:0] ops    [N_OP];
    fcls_t        cls    [N_OP];
    logic [N_OP-1:0] is_nan;
    inv_flags_t   flg;
    logic [W-1:0] pick;

    inv_flags_t   sticky_q, base, merged;
    logic         fx_q, fx_d, vx_q;
    logic         ovr_q;
    logic [W-1:0] res_q;
    logic [3:0]   cond_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign ops[2] = op_c;

    for (genvar g = 0; g < N_OP; g++) begin : g_cls
        fma_cls_operand #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val (ops[g]),
            .cls (cls[g])
        );
        assign is_nan[g] = cls[g].qnan | cls[g].snan;
    end

    fma_cls_invalid u_inv (
        .ca      (cls[0]),
        .cb      (cls[1]),
        .cc      (cls[2]),
        .variant (fma_var_e'(variant)),
        .flg     (flg)
    );

    fma_cls_nan_pick #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pick (
        .ops    (ops),
        .is_nan (is_nan),
        .res    (pick)
    );

    // controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // controller: outputs
    always_comb begin
        out_valid = 1'b0;
        ovr_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DONE: begin
                out_valid = 1'b1;
                ovr_valid = ovr_q;
            end
            default: ;
        endcase
    end

    // sticky merge: clear first, then fold in this operation
    always_comb begin
        base   = clr ? '0 : sticky_q;
        merged = base | (in_valid ? flg : '0);
        fx_d   = (clr ? 1'b0 : fx_q) | (in_valid & |(flg & ~base));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
            fx_q     <= 1'b0;
            vx_q     <= 1'b0;
            ovr_q    <= 1'b0;
            res_q    <= '0;
            cond_q   <= '0;
        end else begin
            if (in_valid || clr) begin
                sticky_q <= merged;
                fx_q     <= fx_d;
                vx_q     <= |merged;
            end
            if (in_valid) begin
                ovr_q <= (|is_nan) | flg.vximz | flg.vxisi;
                res_q <= pick;
                if (record) cond_q <= {fx_d, 1'b0, |merged, 1'b0};
            end
        end
    end

    assign ovr_result = res_q;
    assign st_fx      = fx_q;
    assign st_vx      = vx_q;
    assign st_vximz   = sticky_q.vximz;
    assign st_vxisi   = sticky_q.vxisi;
    assign st_vxsnan  = sticky_q.vxsnan;
    assign cond       = cond_q;
endmodule

// File: rtl/fma_exc_screen_chk.sv
module fma_exc_screen_chk #(
    parameter int EXP_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             in_valid,
    input logic             record,
    input logic             out_valid,
    input logic             ovr_valid,
    input logic [EXP_W-1:0] res_exp,
    input logic             res_qbit,
    input logic             st_fx,
    input logic             st_vx,
    input logic             st_vximz,
    input logic             st_vxisi,
    input logic             st_vxsnan,
    input logic [3:0]       cond
);
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_ovr_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_valid |-> out_valid);

    assert_ovr_is_qnan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_valid |-> (&res_exp) && res_qbit);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (st_vximz || st_vxisi || st_vxsnan)) |=>
        ($past(st_vximz) <= st_vximz) && ($past(st_vxisi) <= st_vxisi) &&
        ($past(st_vxsnan) <= st_vxsnan));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !in_valid) |=> !(st_vximz || st_vxisi || st_vxsnan || st_fx));

    assert_fx_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_fx) |-> $past(in_valid));

    assert_vx_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_vx == (st_vximz || st_vxisi || st_vxsnan));

    assert_cond_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && record) |=> $stable(cond));

    assert_cond_zero_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cond[2] == 1'b0 && cond[0] == 1'b0);
endmodule

bind fma_exc_screen fma_exc_screen_chk #(.EXP_W(EXP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_valid  (in_valid),
    .record    (record),
    .out_valid (out_valid),
    .ovr_valid (ovr_valid),
    .res_exp   (ovr_result[EXP_W+MAN_W-1:MAN_W]),
    .res_qbit  (ovr_result[MAN_W-1]),
    .st_fx     (st_fx),
    .st_vx     (st_vx),
    .st_vximz  (st_vximz),
    .st_vxisi  (st_vxisi),
    .st_vxsnan (st_vxsnan),
    .cond      (cond)
);

// File: tb/tb_fma_exc_screen.sv
module tb_fma_exc_screen;
    localparam int EXP_W = 4;
    localparam int MAN_W = 3;
    localparam int W     = 1 + EXP_W + MAN_W;

    logic         clk = 1'b0;
    logic         rst_n, clr, in_valid, record;
    logic [W-1:0] op_a, op_b, op_c;
    logic [1:0]   variant;
    logic         out_valid, ovr_valid;
    logic [W-1:0] ovr_result;
    logic         st_fx, st_vx, st_vximz, st_vxisi, st_vxsnan;
    logic [3:0]   cond;

    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0] exp_cond = 4'h0;

    always #2.5 clk = ~clk;

    fma_exc_screen #(.EXP_W(EXP_W), .MAN_W(MAN_W)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .variant(variant), .record(record),
        .out_valid(out_valid), .ovr_valid(ovr_valid), .ovr_result(ovr_result),
        .st_fx(st_fx), .st_vx(st_vx), .st_vximz(st_vximz), .st_vxisi(st_vxisi),
        .st_vxsnan(st_vxsnan), .cond(cond)
    );

    // representatives: +0 -0 +inf -inf +normal -subnormal +qnan -snan
    function automatic logic [W-1:0] rep(input int k);
        case (k)
            0: rep = 8'h00;
            1: rep = 8'h80;
            2: rep = 8'h78;
            3: rep = 8'hF8;
            4: rep = 8'h35;
            5: rep = 8'h83;
            6: rep = 8'h7D;
            default: rep = 8'hFB;
        endcase
    endfunction

    function automatic logic f_nan(input logic [W-1:0] v);
        return (v[6:3] == 4'hF) && (v[2:0] != 3'b0);
    endfunction
    function automatic logic f_snan(input logic [W-1:0] v);
        return f_nan(v) && !v[2];
    endfunction
    function automatic logic f_inf(input logic [W-1:0] v);
        return (v[6:3] == 4'hF) && (v[2:0] == 3'b0);
    endfunction
    function automatic logic f_zero(input logic [W-1:0] v);
        return v[6:0] == 7'b0;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // drive one op at a negedge, sample at the following negedge
    task automatic do_op(input logic [W-1:0] a, b, c, input logic [1:0] v,
                         input logic rec, input logic with_clr);
        op_a = a; op_b = b; op_c = c; variant = v; record = rec;
        in_valid = 1'b1; clr = with_clr;
        @(negedge clk);
        in_valid = 1'b0; clr = 1'b0;
    endtask

    task automatic pulse_clr();
        clr = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; record = 1'b0;
        op_a = '0; op_b = '0; op_c = '0; variant = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!out_valid && !ovr_valid, "R1", "reset valid", {out_valid, ovr_valid}, 0);
        chk({st_fx, st_vx, st_vximz, st_vxisi, st_vxsnan} == 5'b0, "R1", "reset flags",
            {st_fx, st_vx, st_vximz, st_vxisi, st_vxsnan}, 0);
        chk(cond == 4'h0, "R10", "reset cond", cond, 0);

        // exhaustive class sweep
        for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
                for (int ic = 0; ic < 8; ic++) begin
                    for (int v = 0; v < 4; v++) begin
                        logic [W-1:0] a, b, c, e_res;
                        logic imz, pinf, isi, sn, e_ovr, rec;
                        a = rep(ia); b = rep(ib); c = rep(ic);
                        rec = logic'((ia + ib + ic + v) % 2);
                        imz  = (f_zero(a) && f_inf(c)) || (f_inf(a) && f_zero(c));
                        pinf = (f_inf(a) && !f_zero(c) && !f_nan(c)) ||
                               (f_inf(c) && !f_zero(a) && !f_nan(a));
                        isi  = pinf && f_inf(b) && ((a[7] ^ c[7]) != (b[7] ^ v[0]));
                        sn   = f_snan(a) || f_snan(b) || f_snan(c);
                        e_ovr = f_nan(a) || f_nan(b) || f_nan(c) || imz || isi;
                        if (f_nan(a))      e_res = a | 8'h04;
                        else if (f_nan(b)) e_res = b | 8'h04;
                        else if (f_nan(c)) e_res = c | 8'h04;
                        else               e_res = 8'h7C;

                        pulse_clr();
                        do_op(a, b, c, 2'(v), rec, 1'b0);
                        if (rec) exp_cond = {imz | isi | sn, 1'b0, imz | isi | sn, 1'b0};

                        chk(out_valid, "R1", "out_valid", out_valid, 1);
                        chk(st_vximz == imz, "R2", "vximz", st_vximz, imz);
                        chk(st_vxisi == isi, "R3", "vxisi", st_vxisi, isi);
                        chk(st_vxsnan == sn, "R4", "vxsnan", st_vxsnan, sn);
                        chk(ovr_valid == e_ovr, "R7", "ovr_valid", ovr_valid, e_ovr);
                        if (e_ovr && (f_nan(a) || f_nan(b) || f_nan(c)))
                            chk(ovr_result == e_res, "R5", "nan result", ovr_result, e_res);
                        else if (e_ovr)
                            chk(ovr_result == e_res, "R6", "default qnan", ovr_result, e_res);
                        chk(st_fx == (imz | isi | sn), "R8", "fx", st_fx, imz | isi | sn);
                        chk(st_vx == (imz | isi | sn), "R8", "vx", st_vx, imz | isi | sn);
                        chk(cond == exp_cond, "R10", "cond", cond, exp_cond);
                    end
                end
            end
        end

        // R9 sticky without clear; R10 record 0 keeps cond
        pulse_clr();
        do_op(8'hFB, 8'h35, 8'h35, 2'b00, 1'b1, 1'b0);
        chk(cond == 4'hA, "R10", "cond snan", cond, 4'hA);
        do_op(8'h35, 8'h35, 8'h35, 2'b10, 1'b0, 1'b0);
        chk(st_vxsnan && st_fx, "R9", "sticky kept", {st_vxsnan, st_fx}, 2'b11);
        chk(!ovr_valid, "R7", "clean op no override", ovr_valid, 0);
        chk(cond == 4'hA, "R10", "cond held", cond, 4'hA);
        @(negedge clk);
        chk(!out_valid, "R1", "idle out_valid", out_valid, 0);

        // R9 clear coinciding with an op
        do_op(8'h00, 8'h35, 8'h78, 2'b11, 1'b1, 1'b1);
        chk(!st_vxsnan && st_vximz, "R9", "clr+op merge", {st_vxsnan, st_vximz}, 2'b01);
        chk(st_fx, "R8", "fx after clr+op", st_fx, 1);
        chk(cond == 4'hA, "R10", "cond clr+op", cond, 4'hA);

        // R10 clear alone leaves cond
        pulse_clr();
        chk({st_fx, st_vx, st_vximz} == 3'b0, "R9", "clr alone", {st_fx, st_vx, st_vximz}, 0);
        chk(cond == 4'hA, "R10", "cond after clr", cond, 4'hA);

        // R10 record with clean op loads zeros
        do_op(8'h35, 8'h00, 8'h35, 2'b01, 1'b1, 1'b0);
        chk(cond == 4'h0, "R10", "cond clean record", cond, 0);

        finish_run();
    end
endmodule